// File: doc/BRIEF.md
# Debug Breakpoint Register File with Pipelined Scan Access

This block is a debug register file reached through one boundary-scan data chain. It holds a bank of breakpoint value and control registers, a bank of watchpoint value and control registers, and a single vector-catch register. Every register is driven straight out of the block to comparator logic that sits elsewhere. The TAP controller is outside the block and drives it with one-cycle capture, shift and update strobes, plus a select that is high while this chain is the active data register.

Each data scan is 40 bits long and carries one request. The request is a direction flag, a data word and a register address. The request executes at the update strobe. Its result is held until the next capture, so the result leaves the chain during the following scan. On the way out, the position that carries the direction flag on the way in reports a ready flag instead. A host therefore ends a batch of requests with one dummy write of zero to address zero, which flushes out the last result.

Top module: `dbg_scan_regfile`

## Requirements
- R1: The asynchronous reset `rst_ni` clears every register and the held result. A scan right after reset shifts out address 0 and data 0.
- R2: A frame is 40 bits, shifted least-significant bit first. Bit 0 is the direction flag (1 = write, 0 = read). Bits 32:1 are the data word. Bits 39:33 are the address. On shift-out, bit 0 is the ready flag and always reads 1.
- R3: The address and data shifted out during a scan belong to the request of the previous scan. For a write, the echoed data equals the data written, whether or not the address is implemented.
- R4: A write to an implemented address updates that register at the update strobe, and the matching output shows it on the next cycle. Outputs change at no other time.
- R5: A read returns the register's contents on the next scan and changes no register.
- R6: Address map: vector catch at 0x07; breakpoint value n at 0x40+n; breakpoint control n at 0x50+n; watchpoint value n at 0x60+n; watchpoint control n at 0x70+n. Here n is less than `NUM_BP` or `NUM_WP`.
- R7: Writes to address 0 or to any unmapped address are ignored. Reads from them return 0.
- R8: While `sel_i` is low, the capture, shift and update strobes have no effect. The held result and the registers are kept.
- R9: A trailing write of data 0 to address 0 shifts out the last real result and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| sel_i | input | 1 | This chain is the selected data register |
| capture_i | input | 1 | TAP is in the capture-data state |
| shift_i | input | 1 | TAP is in the shift-data state |
| update_i | input | 1 | TAP is in the update-data state |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0 of the shift register) |
| bp_value_o | output | NUM_BP*DW | Breakpoint value registers |
| bp_ctrl_o | output | NUM_BP*DW | Breakpoint control registers |
| wp_value_o | output | NUM_WP*DW | Watchpoint value registers |
| wp_ctrl_o | output | NUM_WP*DW | Watchpoint control registers |
| vcatch_o | output | DW | Vector-catch register |

## Verification
A wrong address decode or a wrong write enable shows up on the register outputs in the cycle after the faulty update strobe. It appears either as a change to a register that was not addressed or as a missing change to the one that was. A wrong result register or a bit-order error in the shift register is hidden until the next full scan, where it appears as a misplaced echo address or echo data word. The bench therefore ends every batch with a flush scan. A lost reset or an ignored select shows at the first scan afterwards, through stale echo contents.

// File: rtl/dbg_sc_pkg.sv
package dbg_sc_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned GRP_W  = ADDR_W - SLOT_W;

  localparam logic [GRP_W-1:0]  GRP_BP_VAL = 3'b100;
  localparam logic [GRP_W-1:0]  GRP_BP_CTL = 3'b101;
  localparam logic [GRP_W-1:0]  GRP_WP_VAL = 3'b110;
  localparam logic [GRP_W-1:0]  GRP_WP_CTL = 3'b111;
  localparam logic [ADDR_W-1:0] VC_ADDR    = 7'h07;

  typedef struct packed {
    logic              bp_val;
    logic              bp_ctl;
    logic              wp_val;
    logic              wp_ctl;
    logic              vc;
    logic [SLOT_W-1:0] slot;
  } hit_t;
endpackage

// File: rtl/dbg_sc_shift.sv
module dbg_sc_shift #(
  parameter int unsigned FRAME_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] cap_data_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= cap_data_i;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[FRAME_W-1:1]};
  end

  assign tdo_o   = sr_q[0];
  assign frame_o = sr_q;
endmodule

// File: rtl/dbg_sc_decode.sv
module dbg_sc_decode
  import dbg_sc_pkg::*;
#(
  parameter int unsigned NUM_BP = 16,
  parameter int unsigned NUM_WP = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  localparam logic [SLOT_W:0] BP_LIM = (SLOT_W+1)'(NUM_BP);
  localparam logic [SLOT_W:0] WP_LIM = (SLOT_W+1)'(NUM_WP);

  logic [GRP_W-1:0]  grp;
  logic [SLOT_W-1:0] slot;
  logic              bp_ok, wp_ok;

  always_comb begin
    grp          = addr_i[ADDR_W-1 -: GRP_W];
    slot         = addr_i[SLOT_W-1:0];
    bp_ok        = {1'b0, slot} < BP_LIM;
    wp_ok        = {1'b0, slot} < WP_LIM;
    hit_o.slot   = slot;
    hit_o.bp_val = (grp == GRP_BP_VAL) && bp_ok;
    hit_o.bp_ctl = (grp == GRP_BP_CTL) && bp_ok;
    hit_o.wp_val = (grp == GRP_WP_VAL) && wp_ok;
    hit_o.wp_ctl = (grp == GRP_WP_CTL) && wp_ok;
    hit_o.vc     = (addr_i == VC_ADDR);
  end
endmodule

// File: rtl/dbg_sc_regs.sv
module dbg_sc_regs
  import dbg_sc_pkg::*;
#(
  parameter int unsigned NUM_BP = 16,
  parameter int unsigned NUM_WP = 16,
  parameter int unsigned DW     = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  hit_t                         hit_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                rdata_o,
  output logic [NUM_BP-1:0][DW-1:0]    bp_value_o,
  output logic [NUM_BP-1:0][DW-1:0]    bp_ctrl_o,
  output logic [NUM_WP-1:0][DW-1:0]    wp_value_o,
  output logic [NUM_WP-1:0][DW-1:0]    wp_ctrl_o,
  output logic [DW-1:0]                vcatch_o
);
  logic [NUM_BP-1:0][DW-1:0] bp_val_q, bp_ctl_q;
  logic [NUM_WP-1:0][DW-1:0] wp_val_q, wp_ctl_q;
  logic [DW-1:0]             vc_q;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    logic sel_slot;
    assign sel_slot = we_i && (hit_i.slot == SLOT_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bp_val_q[i] <= '0;
        bp_ctl_q[i] <= '0;
      end else begin
        if (sel_slot && hit_i.bp_val) bp_val_q[i] <= wdata_i;
        if (sel_slot && hit_i.bp_ctl) bp_ctl_q[i] <= wdata_i;
      end
    end
  end

  for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
    logic sel_slot;
    assign sel_slot = we_i && (hit_i.slot == SLOT_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wp_val_q[i] <= '0;
        wp_ctl_q[i] <= '0;
      end else begin
        if (sel_slot && hit_i.wp_val) wp_val_q[i] <= wdata_i;
        if (sel_slot && hit_i.wp_ctl) wp_ctl_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                vc_q <= '0;
    else if (we_i && hit_i.vc)  vc_q <= wdata_i;
  end

  // Unmapped addresses hit nothing and read as zero
  always_comb begin
    rdata_o = '0;
    if (hit_i.vc) rdata_o = vc_q;
    for (int i = 0; i < NUM_BP; i++) begin
      if (hit_i.slot == SLOT_W'(i)) begin
        if (hit_i.bp_val) rdata_o = bp_val_q[i];
        if (hit_i.bp_ctl) rdata_o = bp_ctl_q[i];
      end
    end
    for (int i = 0; i < NUM_WP; i++) begin
      if (hit_i.slot == SLOT_W'(i)) begin
        if (hit_i.wp_val) rdata_o = wp_val_q[i];
        if (hit_i.wp_ctl) rdata_o = wp_ctl_q[i];
      end
    end
  end

  assign bp_value_o = bp_val_q;
  assign bp_ctrl_o  = bp_ctl_q;
  assign wp_value_o = wp_val_q;
  assign wp_ctrl_o  = wp_ctl_q;
  assign vcatch_o   = vc_q;
endmodule

// File: rtl/dbg_scan_regfile.sv
module dbg_scan_regfile
  import dbg_sc_pkg::*;
#(
  parameter int unsigned NUM_BP = 16,
  parameter int unsigned NUM_WP = 16,
  parameter int unsigned DW     = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sel_i,
  input  logic                      capture_i,
  input  logic                      shift_i,
  input  logic                      update_i,
  input  logic                      tdi_i,
  output logic                      tdo_o,
  output logic [NUM_BP-1:0][DW-1:0] bp_value_o,
  output logic [NUM_BP-1:0][DW-1:0] bp_ctrl_o,
  output logic [NUM_WP-1:0][DW-1:0] wp_value_o,
  output logic [NUM_WP-1:0][DW-1:0] wp_ctrl_o,
  output logic [DW-1:0]             vcatch_o
);
  localparam int unsigned FRAME_W = 1 + DW + ADDR_W;

  logic [FRAME_W-1:0] shift_frame, cap_frame;
  logic               req_wr, upd_fire;
  logic [DW-1:0]      req_data, rdata;
  logic [ADDR_W-1:0]  req_addr;
  hit_t               hit;
  logic [ADDR_W-1:0]  res_addr_q;
  logic [DW-1:0]      res_data_q;

  assign req_wr   = shift_frame[0];
  assign req_data = shift_frame[DW:1];
  assign req_addr = shift_frame[FRAME_W-1 -: ADDR_W];
  assign upd_fire = sel_i && update_i;

  // Ready sits in the flag position; accesses complete within the update cycle
  assign cap_frame = {res_addr_q, res_data_q, 1'b1};

  dbg_sc_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (sel_i && capture_i),
    .shift_i    (sel_i && shift_i),
    .cap_data_i (cap_frame),
    .tdi_i      (tdi_i),
    .tdo_o      (tdo_o),
    .frame_o    (shift_frame)
  );

  dbg_sc_decode #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP)) u_decode (
    .addr_i (req_addr),
    .hit_o  (hit)
  );

  dbg_sc_regs #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (upd_fire && req_wr),
    .hit_i      (hit),
    .wdata_i    (req_data),
    .rdata_o    (rdata),
    .bp_value_o (bp_value_o),
    .bp_ctrl_o  (bp_ctrl_o),
    .wp_value_o (wp_value_o),
    .wp_ctrl_o  (wp_ctrl_o),
    .vcatch_o   (vcatch_o)
  );

  // One-deep result pipeline: shifted out on the next scan
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_addr_q <= '0;
      res_data_q <= '0;
    end else if (upd_fire) begin
      res_addr_q <= req_addr;
      res_data_q <= req_wr ? req_data : rdata;
    end
  end
endmodule

// File: rtl/dbg_scan_regfile_chk.sv
module dbg_scan_regfile_chk
  import dbg_sc_pkg::*;
#(
  parameter int unsigned NUM_BP  = 16,
  parameter int unsigned NUM_WP  = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned FRAME_W = 1 + DW + ADDR_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sel_i,
  input logic                      capture_i,
  input logic                      update_i,
  input logic                      tdo_o,
  input logic [FRAME_W-1:0]        frame_i,
  input logic [NUM_BP-1:0][DW-1:0] bp_value_o,
  input logic [NUM_BP-1:0][DW-1:0] bp_ctrl_o,
  input logic [NUM_WP-1:0][DW-1:0] wp_value_o,
  input logic [NUM_WP-1:0][DW-1:0] wp_ctrl_o,
  input logic [DW-1:0]             vcatch_o
);
  logic              upd, wr;
  logic [ADDR_W-1:0] addr;
  assign upd  = sel_i && update_i;
  assign wr   = frame_i[0];
  assign addr = frame_i[FRAME_W-1 -: ADDR_W];

  AST_READY_ON_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && capture_i) |=> tdo_o); // R2

  AST_OUTPUTS_ONLY_AT_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> ($stable(bp_value_o) && $stable(bp_ctrl_o) && $stable(wp_value_o)
              && $stable(wp_ctrl_o) && $stable(vcatch_o))); // R4

  AST_VC_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && wr && addr == VC_ADDR) |=> (vcatch_o == $past(frame_i[DW:1]))); // R4

  AST_READ_NO_SIDE_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && !wr) |=> ($stable(bp_value_o) && $stable(bp_ctrl_o) && $stable(wp_value_o)
                      && $stable(wp_ctrl_o) && $stable(vcatch_o))); // R5

  AST_ADDR0_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && wr && addr == '0) |=> ($stable(bp_value_o) && $stable(bp_ctrl_o)
                                   && $stable(wp_value_o) && $stable(wp_ctrl_o)
                                   && $stable(vcatch_o))); // R7
endmodule

bind dbg_scan_regfile dbg_scan_regfile_chk #(
  .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .DW(DW)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .capture_i  (capture_i),
  .update_i   (update_i),
  .tdo_o      (tdo_o),
  .frame_i    (shift_frame),
  .bp_value_o (bp_value_o),
  .bp_ctrl_o  (bp_ctrl_o),
  .wp_value_o (wp_value_o),
  .wp_ctrl_o  (wp_ctrl_o),
  .vcatch_o   (vcatch_o)
);

// File: tb/dbg_scan_regfile_tb.sv
module dbg_scan_regfile_tb_top;
  localparam int NB = 16;
  localparam int NW = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sel_i = 1'b0, capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, tdi_i = 1'b0;
  logic tdo_o;
  logic [NB-1:0][31:0] bp_value_o, bp_ctrl_o;
  logic [NW-1:0][31:0] wp_value_o, wp_ctrl_o;
  logic [31:0] vcatch_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk_i = ~clk_i;

  dbg_scan_regfile #(.NUM_BP(NB), .NUM_WP(NW), .DW(32)) dut_i (
    .clk_i, .rst_ni, .sel_i, .capture_i, .shift_i, .update_i, .tdi_i, .tdo_o,
    .bp_value_o, .bp_ctrl_o, .wp_value_o, .wp_ctrl_o, .vcatch_o
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_scan(input logic sel, input logic wr, input logic [31:0] d,
                         input logic [6:0] a, output logic rdy,
                         output logic [31:0] od, output logic [6:0] oa);
    logic [39:0] in_v, out_v;
    in_v = {a, d, wr};
    sel_i = sel;
    capture_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    capture_i = 1'b0;
    shift_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tdi_i = in_v[i];
      out_v[i] = tdo_o;
      @(posedge clk_i); @(negedge clk_i);
    end
    shift_i = 1'b0;
    update_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    update_i = 1'b0;
    sel_i = 1'b0;
    rdy = out_v[0];
    od  = out_v[32:1];
    oa  = out_v[39:33];
  endtask

  // Scan and check the echoed result of the previous request
  task automatic scan_expect(input logic wr, input logic [31:0] d, input logic [6:0] a,
                             input logic [31:0] ed, input logic [6:0] ea, input string req);
    logic rdy; logic [31:0] od; logic [6:0] oa;
    do_scan(1'b1, wr, d, a, rdy, od, oa);
    check(rdy === 1'b1, "R2 ready flag", 64'(rdy), 64'd1);
    check(oa === ea, {req, " echo address"}, 64'(oa), 64'(ea));
    check(od === ed, {req, " echo data"}, 64'(od), 64'(ed));
  endtask

  task automatic t_reset();
    check(vcatch_o === '0 && bp_value_o === '0 && bp_ctrl_o === '0 &&
          wp_value_o === '0 && wp_ctrl_o === '0, "R1 outputs zero after reset",
          64'(vcatch_o), 64'd0);
    scan_expect(1'b0, 32'h0, 7'h00, 32'h0, 7'h00, "R1 first scan after reset");
  endtask

  task automatic t_write_vc();
    scan_expect(1'b1, 32'hA5C3_0F01, 7'h07, 32'h0, 7'h00, "R3 prior read of addr 0");
    check(vcatch_o === 32'hA5C3_0F01, "R4 vector catch written", 64'(vcatch_o), 64'hA5C30F01);
    scan_expect(1'b1, 32'h0, 7'h00, 32'hA5C3_0F01, 7'h07, "R9 flush shows write echo");
  endtask

  task automatic t_banks();
    scan_expect(1'b1, 32'h1234_5678, 7'h40, 32'h0, 7'h00, "R3 after flush");
    scan_expect(1'b1, 32'h0000_01E7, 7'h5F, 32'h1234_5678, 7'h40, "R3 bp value echo");
    scan_expect(1'b1, 32'hDEAD_BEEF, 7'h63, 32'h0000_01E7, 7'h5F, "R3 bp ctrl echo");
    scan_expect(1'b1, 32'h8000_0001, 7'h79, 32'hDEAD_BEEF, 7'h63, "R3 wp value echo");
    check(bp_value_o[0] === 32'h1234_5678, "R6 bp value slot 0", 64'(bp_value_o[0]), 64'h12345678);
    check(bp_ctrl_o[15] === 32'h0000_01E7, "R6 bp ctrl slot 15", 64'(bp_ctrl_o[15]), 64'h1E7);
    check(wp_value_o[3] === 32'hDEAD_BEEF, "R6 wp value slot 3", 64'(wp_value_o[3]), 64'hDEADBEEF);
    check(wp_ctrl_o[9] === 32'h8000_0001, "R6 wp ctrl slot 9", 64'(wp_ctrl_o[9]), 64'h80000001);
    check(bp_value_o[1] === '0 && wp_ctrl_o[8] === '0, "R4 neighbours untouched",
          64'(bp_value_o[1]), 64'd0);
  endtask

  task automatic t_read();
    scan_expect(1'b0, 32'hFFFF_FFFF, 7'h40, 32'h8000_0001, 7'h79, "R3 wp ctrl echo");
    scan_expect(1'b0, 32'h0, 7'h63, 32'h1234_5678, 7'h40, "R5 read bp value");
    scan_expect(1'b0, 32'h0, 7'h07, 32'hDEAD_BEEF, 7'h63, "R5 read wp value");
    scan_expect(1'b1, 32'h0, 7'h00, 32'hA5C3_0F01, 7'h07, "R9 flush returns vc read");
    check(bp_value_o[0] === 32'h1234_5678 && vcatch_o === 32'hA5C3_0F01,
          "R5 reads leave registers", 64'(vcatch_o), 64'hA5C30F01);
  endtask

  task automatic t_unmapped();
    scan_expect(1'b1, 32'hFFFF_FFFF, 7'h00, 32'h0, 7'h00, "R9 previous flush echo");
    scan_expect(1'b1, 32'hCAFE_F00D, 7'h25, 32'hFFFF_FFFF, 7'h00, "R3 addr 0 write echo");
    scan_expect(1'b0, 32'h0, 7'h25, 32'hCAFE_F00D, 7'h25, "R3 unmapped write echo");
    scan_expect(1'b0, 32'h0, 7'h00, 32'h0, 7'h25, "R7 unmapped read zero");
    scan_expect(1'b1, 32'h0, 7'h00, 32'h0, 7'h00, "R7 addr 0 read zero");
    check(vcatch_o === 32'hA5C3_0F01 && bp_value_o[0] === 32'h1234_5678 &&
          wp_value_o[3] === 32'hDEAD_BEEF, "R7 ignored writes", 64'(vcatch_o), 64'hA5C30F01);
  endtask

  task automatic t_deselect();
    logic rdy; logic [31:0] od; logic [6:0] oa;
    scan_expect(1'b0, 32'h0, 7'h07, 32'h0, 7'h00, "R9 flush echo");
    do_scan(1'b0, 1'b1, 32'h0BAD_0BAD, 7'h07, rdy, od, oa);
    check(vcatch_o === 32'hA5C3_0F01, "R8 deselected write ignored", 64'(vcatch_o), 64'hA5C30F01);
    scan_expect(1'b1, 32'h0, 7'h00, 32'hA5C3_0F01, 7'h07, "R8 result held while deselected");
  endtask

  task automatic t_reset_mid();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(vcatch_o === '0 && bp_value_o === '0 && wp_ctrl_o === '0,
          "R1 reset clears registers", 64'(vcatch_o), 64'd0);
    scan_expect(1'b0, 32'h0, 7'h07, 32'h0, 7'h00, "R1 reset clears result");
    scan_expect(1'b1, 32'h0, 7'h00, 32'h0, 7'h07, "R1 vc reads zero after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write_vc();
    t_banks();
    t_read();
    t_unmapped();
    t_deselect();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule